// File: doc/BRIEF.md
# Serial Audio Link Input Frame Receiver

This block sits on the controller side of a time-slotted serial audio link. It is clocked by the bit clock that the codec supplies. It watches the frame sync line to find where each input frame starts, and it samples the serial input line bit by bit. Each frame is 256 bit times long. It opens with a 16-bit tag slot and carries twelve 20-bit data slots after that.

The tag slot tells the receiver two things: whether the codec is ready, and which of the twelve data slots hold valid samples. The receiver collects the slot words as they arrive. Once the final bit of the frame has been sampled, it publishes the ready flag, the valid mask and all twelve words at once, together with a one-cycle completion strobe. The published values then stay fixed until the next frame completes.

When a frame reports that the codec is not ready, the published mask and words are all zero. A sync rising edge that arrives in the middle of a frame realigns the receiver to a new frame, and the partial frame is dropped.

Top module: `slink_rx_deser`

## Requirements
- R1: While `rst` is high at a falling edge of `bit_clk`, the receiver clears `ready_o`, `valid_o`, `slot_data_o` and `frame_done_o` to zero, and its frame position becomes idle.
- R2: After reset, no bit is captured and `frame_done_o` stays low until `sync_in` is seen low at one falling edge and high at the next one. That second falling edge is the frame-start reference.
- R3: All inputs are sampled on falling edges of `bit_clk`. Frame bit 0 is the bit sampled at the first falling edge after the frame-start reference, and bit k is sampled k edges later.
- R4: Frame bit 0 is the codec-ready flag (1 = ready). At frame completion its value appears on `ready_o`.
- R5: Frame bits 1 to 12 are the valid flags for slots 1 to 12, in that order. Bit k is published on `valid_o[k-1]`, so `valid_o[0]` belongs to slot 1.
- R6: Slot s (1 to 12) occupies frame bits 16+20(s-1) to 35+20(s-1) and is sent most significant bit first. Its word is published on `slot_data_o[20(s-1)+19 : 20(s-1)]`.
- R7: When the ready flag of a frame is 0, that frame publishes `ready_o`=0, `valid_o`=0 and an all-zero `slot_data_o`, whatever the valid flags and data bits were.
- R8: Frame bits 13, 14 and 15 have no effect on any output.
- R9: `frame_done_o` goes high for exactly one cycle, right after the falling edge that samples frame bit 255. The published outputs update at that same edge and hold their values until the next such edge.
- R10: If no new sync rising edge arrives, the frame position wraps after bit 255, and the next 256 bits are received as a complete frame.
- R11: A sync rising edge seen partway through a frame restarts the frame position. The partial frame produces no strobe and leaves the published outputs unchanged.
- R12: A reset in the middle of a stream drops the frame in progress. Data sent after reset without a new sync rising edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock from the codec; all logic uses its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Frame sync line; a rising edge marks a new frame |
| sdata_in | input | 1 | Serial input data from the codec |
| ready_o | output | 1 | Codec-ready flag of the last completed frame |
| valid_o | output | 12 | Per-slot valid flags; bit 0 is slot 1 |
| slot_data_o | output | 240 | Twelve 20-bit slot words; slot 1 is in the low bits |
| frame_done_o | output | 1 | One-cycle strobe when a frame's outputs are published |

## Verification
Each bit the bench drives on a rising edge is sampled at the very next falling edge. The strobe and the published outputs go through one register, so they change on that same falling edge: the edge that samples bit 255. The bench therefore reads results 1 ns after that falling edge. It confirms that the strobe has dropped one falling edge later, while the next frame's bit 0 is being sampled. Partial frames, resets and unsynchronized data are judged through the running count of strobes and the held output values at the next falling edge, never mid-cycle.

// File: rtl/slink_rx_pkg.sv
package slink_rx_pkg;

   // bits needed to encode values 0 .. n-1, never less than one
   function automatic int unsigned enc_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   function automatic int unsigned larger(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/slink_rx_timer.sv
// Frame position tracker: sync edge detection, slot index and bit position.
module slink_rx_timer #(
   parameter int unsigned SLOT0_W = 16,
   parameter int unsigned SLOT_W  = 20,
   parameter int unsigned N_SLOTS = 12,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned POS_W   = 5
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             sync_in,
   output logic             bit_en,
   output logic [IDX_W-1:0] slot_idx,
   output logic [POS_W-1:0] bit_pos,
   output logic             frame_last
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SLOTS);
   localparam logic [POS_W-1:0] TAG_END  = POS_W'(SLOT0_W - 1);
   localparam logic [POS_W-1:0] DATA_END = POS_W'(SLOT_W - 1);

   logic             sync_q;
   logic             active_q;
   logic [IDX_W-1:0] idx_q;
   logic [POS_W-1:0] pos_q;
   logic             sync_rise;
   logic             slot_end;
   logic             in_last_slot;

   always_comb begin
      sync_rise    = sync_in & ~sync_q;
      in_last_slot = (idx_q == LAST_IDX);
      slot_end     = (idx_q == '0) ? (pos_q == TAG_END) : (pos_q == DATA_END);
   end

   assign bit_en     = active_q;
   assign slot_idx   = idx_q;
   assign bit_pos    = pos_q;
   assign frame_last = active_q & in_last_slot & slot_end;

   always_ff @(negedge clk) begin
      if (rst) begin
         sync_q   <= sync_in;
         active_q <= 1'b0;
         idx_q    <= '0;
         pos_q    <= '0;
      end else begin
         sync_q <= sync_in;
         if (sync_rise) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            pos_q    <= '0;
         end else if (active_q) begin
            if (slot_end) begin
               pos_q <= '0;
               idx_q <= in_last_slot ? '0 : idx_q + 1'b1;
            end else begin
               pos_q <= pos_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/slink_rx_tag.sv
// Tag slot capture: ready flag at position 0, slot valid flags after it.
module slink_rx_tag #(
   parameter int unsigned N_SLOTS = 12,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned POS_W   = 5
)(
   input  logic               clk,
   input  logic               rst,
   input  logic               bit_en,
   input  logic [IDX_W-1:0]   slot_idx,
   input  logic [POS_W-1:0]   bit_pos,
   input  logic               sdata,
   output logic               ready_tag,
   output logic [N_SLOTS-1:0] valid_tag
);
   logic [N_SLOTS:0] tag_q;
   logic             in_tag;

   assign in_tag = bit_en && (slot_idx == '0);

   // positions above N_SLOTS fall through every compare and are dropped
   always_ff @(negedge clk) begin
      if (rst) begin
         tag_q <= '0;
      end else if (in_tag) begin
         for (int p = 0; p <= int'(N_SLOTS); p++) begin
            if (bit_pos == POS_W'(p)) tag_q[p] <= sdata;
         end
      end
   end

   assign ready_tag = tag_q[0];
   assign valid_tag = tag_q[N_SLOTS:1];

endmodule

// File: rtl/slink_rx_capture.sv
// Slot word capture, either one shift register per slot or one shared shifter.
module slink_rx_capture #(
   parameter int unsigned N_SLOTS = 12,
   parameter int unsigned SLOT_W  = 20,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned POS_W   = 5,
   parameter bit          SHARED  = 1'b0
)(
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      bit_en,
   input  logic [IDX_W-1:0]          slot_idx,
   input  logic [POS_W-1:0]          bit_pos,
   input  logic                      sdata,
   output logic [N_SLOTS*SLOT_W-1:0] words_nxt
);
   localparam logic [POS_W-1:0] WORD_END = POS_W'(SLOT_W - 1);

   generate
      if (SHARED) begin : g_shared
         logic [SLOT_W-2:0] sh_q;
         logic              in_data;
         logic              at_end;

         assign in_data = bit_en && (slot_idx != '0);
         assign at_end  = in_data && (bit_pos == WORD_END);

         always_ff @(negedge clk) begin
            if (rst) sh_q <= '0;
            else if (in_data) sh_q <= (SLOT_W-1)'({sh_q, sdata});
         end

         for (genvar s = 0; s < int'(N_SLOTS); s++) begin : g_slot
            logic [SLOT_W-1:0] stage_q;
            logic              wr;
            assign wr = at_end && (slot_idx == IDX_W'(s + 1));
            always_ff @(negedge clk) begin
               if (rst) stage_q <= '0;
               else if (wr) stage_q <= {sh_q, sdata};
            end
            assign words_nxt[s*SLOT_W +: SLOT_W] = wr ? {sh_q, sdata} : stage_q;
         end
      end else begin : g_per_slot
         logic [POS_W-1:0] unused_pos;
         assign unused_pos = bit_pos;

         for (genvar s = 0; s < int'(N_SLOTS); s++) begin : g_slot
            logic [SLOT_W-1:0] sr_q;
            logic              hit;
            assign hit = bit_en && (slot_idx == IDX_W'(s + 1));
            always_ff @(negedge clk) begin
               if (rst) sr_q <= '0;
               else if (hit) sr_q <= {sr_q[SLOT_W-2:0], sdata};
            end
            assign words_nxt[s*SLOT_W +: SLOT_W] = hit ? {sr_q[SLOT_W-2:0], sdata} : sr_q;
         end
      end
   endgenerate

endmodule

// File: rtl/slink_rx_deser.sv
// Input frame receiver top: timer, tag capture, slot capture, output latch.
module slink_rx_deser
   import slink_rx_pkg::*;
#(
   parameter int unsigned SLOT0_W      = 16,
   parameter int unsigned SLOT_W       = 20,
   parameter int unsigned N_SLOTS      = 12,
   parameter bit          SHARED_SHIFT = 1'b0
)(
   input  logic                      bit_clk,
   input  logic                      rst,
   input  logic                      sync_in,
   input  logic                      sdata_in,
   output logic                      ready_o,
   output logic [N_SLOTS-1:0]        valid_o,
   output logic [N_SLOTS*SLOT_W-1:0] slot_data_o,
   output logic                      frame_done_o
);
   localparam int unsigned IDX_W = enc_width(N_SLOTS + 1);
   localparam int unsigned POS_W = enc_width(larger(SLOT0_W, SLOT_W));

   generate
      if (N_SLOTS < 1) begin : g_chk_slots
         $error("N_SLOTS must be at least 1");
      end
      if (SLOT0_W < N_SLOTS + 1) begin : g_chk_tag
         $error("SLOT0_W too narrow for ready flag plus valid flags");
      end
      if (SLOT_W < 2) begin : g_chk_width
         $error("SLOT_W must be at least 2");
      end
   endgenerate

   logic                      bit_en;
   logic [IDX_W-1:0]          slot_idx;
   logic [POS_W-1:0]          bit_pos;
   logic                      frame_last;
   logic                      ready_tag;
   logic [N_SLOTS-1:0]        valid_tag;
   logic [N_SLOTS*SLOT_W-1:0] words_nxt;

   slink_rx_timer #(
      .SLOT0_W(SLOT0_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS),
      .IDX_W(IDX_W), .POS_W(POS_W)
   ) u_timer (
      .clk(bit_clk), .rst(rst), .sync_in(sync_in),
      .bit_en(bit_en), .slot_idx(slot_idx), .bit_pos(bit_pos),
      .frame_last(frame_last)
   );

   slink_rx_tag #(
      .N_SLOTS(N_SLOTS), .IDX_W(IDX_W), .POS_W(POS_W)
   ) u_tag (
      .clk(bit_clk), .rst(rst), .bit_en(bit_en), .slot_idx(slot_idx),
      .bit_pos(bit_pos), .sdata(sdata_in),
      .ready_tag(ready_tag), .valid_tag(valid_tag)
   );

   slink_rx_capture #(
      .N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .POS_W(POS_W),
      .SHARED(SHARED_SHIFT)
   ) u_cap (
      .clk(bit_clk), .rst(rst), .bit_en(bit_en), .slot_idx(slot_idx),
      .bit_pos(bit_pos), .sdata(sdata_in), .words_nxt(words_nxt)
   );

   always_ff @(negedge bit_clk) begin
      if (rst) begin
         ready_o      <= 1'b0;
         valid_o      <= '0;
         slot_data_o  <= '0;
         frame_done_o <= 1'b0;
      end else begin
         frame_done_o <= frame_last;
         if (frame_last) begin
            ready_o     <= ready_tag;
            valid_o     <= ready_tag ? valid_tag : '0;
            slot_data_o <= ready_tag ? words_nxt : '0;
         end
      end
   end

endmodule

// File: rtl/slink_rx_deser_chk.sv
// Property checker, bound to the receiver top.
module slink_rx_deser_chk #(
   parameter int unsigned SLOT0_W = 16,
   parameter int unsigned SLOT_W  = 20,
   parameter int unsigned N_SLOTS = 12
)(
   input logic                      clk,
   input logic                      rst,
   input logic                      sync_in,
   input logic                      ready_o,
   input logic [N_SLOTS-1:0]        valid_o,
   input logic [N_SLOTS*SLOT_W-1:0] slot_data_o,
   input logic                      frame_done_o
);
   localparam int unsigned FRAME_BITS = SLOT0_W + N_SLOTS * SLOT_W;
   localparam int unsigned PH_W       = $clog2(FRAME_BITS) + 1;

   logic            sq;
   logic            primed;
   logic [PH_W-1:0] ph;

   // edges since the last sync rise, modulo the frame length
   always_ff @(negedge clk) begin
      if (rst) begin
         sq     <= sync_in;
         primed <= 1'b0;
         ph     <= '0;
      end else begin
         sq <= sync_in;
         if (sync_in && !sq) begin
            primed <= 1'b1;
            ph     <= '0;
         end else begin
            ph <= (ph == PH_W'(FRAME_BITS - 1)) ? '0 : ph + 1'b1;
         end
      end
   end

   // R1
   reset_clear_chk: assert property (@(negedge clk)
      $past(rst) |-> (!ready_o && valid_o == '0 && slot_data_o == '0 && !frame_done_o));

   // R2 R10 R11
   frame_phase_chk: assert property (@(negedge clk) disable iff (rst)
      frame_done_o |-> (primed && ph == '0));

   // R9
   done_pulse_chk: assert property (@(negedge clk) disable iff (rst)
      frame_done_o |=> !frame_done_o);

   // R9
   hold_between_chk: assert property (@(negedge clk) disable iff (rst)
      (!$past(rst) && !frame_done_o) |->
         ($stable(ready_o) && $stable(valid_o) && $stable(slot_data_o)));

   // R7
   not_ready_zero_chk: assert property (@(negedge clk) disable iff (rst)
      !ready_o |-> (valid_o == '0 && slot_data_o == '0));

endmodule

bind slink_rx_deser slink_rx_deser_chk #(
   .SLOT0_W(SLOT0_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)
) u_chk (
   .clk(bit_clk), .rst(rst), .sync_in(sync_in), .ready_o(ready_o),
   .valid_o(valid_o), .slot_data_o(slot_data_o), .frame_done_o(frame_done_o)
);

// File: tb/tb_slink_rx_deser.sv
module tb_slink_rx_deser;
   localparam int S0 = 16;
   localparam int SW = 20;
   localparam int NS = 12;
   localparam int FB = S0 + NS * SW;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sync = 1'b0;
   logic sd = 1'b0;
   logic ready;
   logic [NS-1:0] valid;
   logic [NS*SW-1:0] data;
   logic done;

   slink_rx_deser dut (
      .bit_clk(clk), .rst(rst), .sync_in(sync), .sdata_in(sd),
      .ready_o(ready), .valid_o(valid), .slot_data_o(data), .frame_done_o(done)
   );

   always #4 clk = ~clk;

   int total = 0;
   int bad = 0;
   int done_cnt = 0;
   logic fb [0:FB-1];
   logic exp_rdy;
   logic [NS-1:0] exp_vm;
   logic [NS*SW-1:0] exp_data;
   logic [NS*SW-1:0] held_data;

   always @(posedge clk) if (done === 1'b1) done_cnt++;

   task automatic check(input string what, input logic [NS*SW-1:0] act, input logic [NS*SW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", what, act, exp);
      end
   endtask

   function automatic logic [SW-1:0] wgen(input int s, input int seed);
      int unsigned v;
      v = (32'(seed) * 32'd48271) ^ (32'(s) * 32'd7919) ^ (32'd1 << (s + seed % 5));
      return v[SW-1:0] ^ SW'(s * seed * 131);
   endfunction

   task automatic build(input logic rdy, input logic [NS-1:0] vm, input int seed, input logic [2:0] junk);
      fb[0] = rdy;
      for (int s = 1; s <= NS; s++) fb[s] = vm[s-1];
      for (int j = 0; j < 3; j++) fb[NS+1+j] = junk[j];
      for (int s = 1; s <= NS; s++) begin
         logic [SW-1:0] w;
         w = wgen(s, seed);
         for (int b = 0; b < SW; b++) fb[S0 + (s-1)*SW + b] = w[SW-1-b];
         exp_data[(s-1)*SW +: SW] = rdy ? w : '0;
      end
      exp_rdy = rdy;
      exp_vm  = rdy ? vm : '0;
   endtask

   task automatic play(input int n, input bit lead, input bit sync_last, input bit chk_low);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         sd   = fb[i];
         sync = (lead && i < 15) || (sync_last && i == n - 1);
         if (i == 0 && chk_low) begin
            @(negedge clk); #1;
            check("R9 strobe low one edge later", done, 0);
         end
      end
   endtask

   task automatic expect_frame(input string req);
      @(negedge clk); #1;
      check({req, " R9 strobe"}, done, 1);
      check({req, " R4 ready"}, ready, exp_rdy);
      check({req, " R5 valid mask"}, valid, exp_vm);
      check({req, " R6 slot words"}, data, exp_data);
   endtask

   initial begin
      #800000;
      bad++;
      total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      #1;
      check("R1 ready", ready, 0);
      check("R1 valid", valid, 0);
      check("R1 data", data, 0);
      check("R1 strobe", done, 0);
      @(posedge clk);
      rst = 1'b0;

      // R2 data without sync is not captured
      for (int i = 0; i < 300; i++) begin
         @(posedge clk);
         sd = i[0] ^ i[3];
         sync = 1'b0;
      end
      @(negedge clk); #1;
      check("R2 no strobe without sync", 32'(done_cnt), 0);
      check("R2 ready stays low", ready, 0);

      @(posedge clk);
      sync = 1'b1;
      sd = 1'b0;

      build(1'b1, 12'hA5C, 1, 3'b000);
      play(FB, 1, 1, 0);
      expect_frame("R3 F1");

      build(1'b1, 12'hFFF, 2, 3'b000);
      play(FB, 1, 1, 1);
      expect_frame("R3 F2");

      build(1'b1, 12'h001, 3, 3'b000);
      play(FB, 1, 1, 1);
      expect_frame("R6 F3");

      build(1'b0, 12'hFFF, 4, 3'b000);
      play(FB, 1, 1, 1);
      expect_frame("R7 not ready");

      build(1'b1, 12'h3C3, 5, 3'b111);
      play(FB, 1, 0, 1);
      expect_frame("R8 ignored tag bits");

      build(1'b1, 12'h5A6, 6, 3'b000);
      play(FB, 0, 0, 1);
      expect_frame("R10 wrap");
      held_data = exp_data;

      // R11 sync rise in mid frame
      build(1'b1, 12'hFFF, 7, 3'b000);
      play(100, 0, 1, 1);
      @(negedge clk); #1;
      check("R11 no strobe on partial", done, 0);
      check("R11 strobe count", 32'(done_cnt), 6);
      check("R11 outputs held", data, held_data);

      build(1'b1, 12'h8E1, 8, 3'b010);
      play(FB, 1, 0, 1);
      expect_frame("R11 realigned");

      // R12 reset mid stream
      build(1'b1, 12'hFFF, 9, 3'b000);
      play(50, 0, 0, 1);
      @(posedge clk);
      rst = 1'b1;
      sync = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      check("R12 ready cleared", ready, 0);
      check("R12 data cleared", data, 0);
      check("R12 strobe cleared", done, 0);
      @(posedge clk);
      rst = 1'b0;

      build(1'b1, 12'hFFF, 10, 3'b000);
      play(FB, 0, 0, 0);
      @(negedge clk); #1;
      check("R12 no capture without sync", 32'(done_cnt), 7);
      check("R12 ready still low", ready, 0);

      @(posedge clk);
      sync = 1'b1;
      sd = 1'b0;
      build(1'b1, 12'h135, 11, 3'b000);
      play(FB, 1, 0, 0);
      expect_frame("R12 after resync");
      @(posedge clk); #1;
      check("R9 total strobes", 32'(done_cnt), 8);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule